// File: doc/BRIEF.md
# Single-Accumulator Processor with Interrupt Phase

This block is a small sequential processor built around one accumulator, a program counter and an instruction register. It runs each instruction as a fixed walk: fetch, execute, an optional operand read, and then an interrupt-check phase. It owns a word-addressed synchronous memory. While reset is held, the memory can be filled through a loader port, so a program and its data are placed before the first fetch.

The interrupt-check phase follows every executed instruction except halt. When the request line is high and interrupts are enabled, the processor saves the return address and the accumulator in shadow registers and clears the enable. It then jumps to a fixed handler address. A return instruction copies the shadow values back and sets the enable again, so the interrupted program continues with its next instruction. Each memory write the processor makes is visible at the ports, together with the live PC, the accumulator, the enable flag, a halt indication and a one-cycle pulse when an interrupt is taken.

Top module: `acc_cpu`

## Requirements
- R1: While reset is high and in the first cycle after it falls, pc_out equals RESET_PC (default 0x300), acc_out is 0, halted is 0, int_en is 1 and st_valid is 0.
- R2: An instruction word has its opcode in bits 15:12 and its address in bits 11:0. Opcode 0x1 puts the addressed memory word into the accumulator.
- R3: Opcode 0x5 adds the addressed memory word to the accumulator. The sum wraps modulo 2^16.
- R4: Opcode 0x2 writes the accumulator to the addressed word. st_valid is high for exactly one cycle with st_addr and st_data. The accumulator is unchanged, and a later read of that address returns the stored value.
- R5: Because the memory has one cycle of read latency, load and add take 5 cycles. Store, return and unused opcodes take 4 cycles. The PC advances by one for each fetched word.
- R6: In the check phase, if irq is 1 and int_en is 1, irq_taken pulses for one cycle. In the next cycle pc_out equals HANDLER_PC (default 0x100) and int_en is 0.
- R7: While int_en is 0, irq is ignored: no irq_taken pulse occurs and the program flow is unchanged.
- R8: Opcode 0xE restores the PC (the address after the interrupted instruction) and the accumulator from the shadow copies, and sets int_en to 1.
- R9: Opcode 0xF sets halted to 1 permanently. The PC freezes at the address after the halt word, and no further store happens.
- R10: The loader port (ld_en, ld_addr, ld_data) writes memory only while reset is high. When reset is low it has no effect.
- R11: Opcodes other than 0x1, 0x2, 0x5, 0xE and 0xF act as no-ops and leave the accumulator unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ld_en | input | 1 | Loader write strobe, used only while rst is high |
| ld_addr | input | 12 | Loader word address |
| ld_data | input | 16 | Loader write data |
| irq | input | 1 | Interrupt request level |
| halted | output | 1 | High once a halt instruction has executed |
| pc_out | output | 12 | Current program counter |
| acc_out | output | 16 | Current accumulator |
| int_en | output | 1 | Interrupt enable flag |
| irq_taken | output | 1 | One-cycle pulse when an interrupt is accepted |
| st_valid | output | 1 | Processor memory write this cycle |
| st_addr | output | 12 | Address of the processor write |
| st_data | output | 16 | Data of the processor write |

## Verification
The preloaded program runs three chains:
- a load, add and store chain (3 + 2 = 5), followed by a reload of the stored word, which proves the write reached memory;
- an unused opcode placed between two stores, which separates a no-op from a decode that corrupts the accumulator;
- an add of 0xFFFF, which exposes any carry kept beyond 16 bits.

One interrupt is raised right after a store. The request is held high through the first part of the handler. This separates correct masking from re-entry, and shows whether the return restores both the PC and the accumulator, because the resumed add depends on the restored value. A loader write made after reset falls would change that same add if it were not ignored. The gaps in cycles between stores separate the 5-cycle memory-reading instructions from the 4-cycle ones.

// File: rtl/acc_cpu_pkg.sv
package acc_cpu_pkg;

    localparam int WORD_W = 16;
    localparam int OPC_W  = 4;
    localparam int ADDR_W = WORD_W - OPC_W;

    localparam logic [OPC_W-1:0] OPC_LOAD  = 4'h1;
    localparam logic [OPC_W-1:0] OPC_STORE = 4'h2;
    localparam logic [OPC_W-1:0] OPC_ADD   = 4'h5;
    localparam logic [OPC_W-1:0] OPC_RETI  = 4'hE;
    localparam logic [OPC_W-1:0] OPC_HALT  = 4'hF;

    typedef struct packed {
        logic [OPC_W-1:0]  op;
        logic [ADDR_W-1:0] addr;
    } instr_t;

    typedef struct packed {
        logic [ADDR_W-1:0] pc;
        logic [WORD_W-1:0] acc;
    } context_t;

    typedef enum logic [2:0] {
        PH_FETCH_REQ,
        PH_FETCH_WAIT,
        PH_EXEC,
        PH_OPER_WAIT,
        PH_ICHECK,
        PH_HALT
    } phase_e;

    typedef enum logic [2:0] {
        K_LOAD,
        K_ADD,
        K_STORE,
        K_RETI,
        K_HALT,
        K_NOP
    } kind_e;

    function automatic kind_e classify(input logic [OPC_W-1:0] op);
        kind_e k;
        case (op)
            OPC_LOAD:  k = K_LOAD;
            OPC_ADD:   k = K_ADD;
            OPC_STORE: k = K_STORE;
            OPC_RETI:  k = K_RETI;
            OPC_HALT:  k = K_HALT;
            default:   k = K_NOP;
        endcase
        return k;
    endfunction

endpackage

// File: rtl/acc_mem.sv
module acc_mem #(
    parameter int AW = acc_cpu_pkg::ADDR_W,
    parameter int DW = acc_cpu_pkg::WORD_W
) (
    input  logic          clk,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [DW-1:0] wdata,
    input  logic [AW-1:0] raddr,
    output logic [DW-1:0] rdata
);
    localparam int DEPTH = 1 << AW;

    logic [DW-1:0] store_q [DEPTH];

    always_ff @(posedge clk) begin
        if (we) begin
            store_q[waddr] <= wdata;
        end
        rdata <= store_q[raddr];
    end
endmodule

// File: rtl/acc_ctx.sv
module acc_ctx
    import acc_cpu_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     save,
    input  logic     restore,
    input  context_t live,
    output context_t saved,
    output logic     int_en
);
    always_ff @(posedge clk) begin
        if (rst) begin
            saved  <= '0;
            int_en <= 1'b1;
        end else if (save) begin
            saved  <= live;
            int_en <= 1'b0;
        end else if (restore) begin
            int_en <= 1'b1;
        end
    end
endmodule

// File: rtl/acc_ctrl.sv
module acc_ctrl
    import acc_cpu_pkg::*;
#(
    parameter logic [ADDR_W-1:0] RESET_PC   = 12'h300,
    parameter logic [ADDR_W-1:0] HANDLER_PC = 12'h100
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [WORD_W-1:0] rdata,
    input  logic              irq,
    input  logic              int_en,
    input  context_t          saved,
    output logic [ADDR_W-1:0] rd_addr,
    output logic              wr_en,
    output logic [ADDR_W-1:0] wr_addr,
    output logic [WORD_W-1:0] wr_data,
    output logic              save,
    output logic              restore,
    output context_t          live,
    output logic              halted,
    output logic              irq_taken
);
    phase_e            phase;
    instr_t            ir;
    logic [ADDR_W-1:0] pc;
    logic [WORD_W-1:0] acc;
    kind_e             kind;

    assign kind = classify(ir.op);

    always_comb begin
        rd_addr   = (phase == PH_EXEC) ? ir.addr : pc;
        wr_en     = (phase == PH_EXEC) && (kind == K_STORE);
        wr_addr   = ir.addr;
        wr_data   = acc;
        save      = (phase == PH_ICHECK) && irq && int_en;
        restore   = (phase == PH_EXEC) && (kind == K_RETI);
        live.pc   = pc;
        live.acc  = acc;
        halted    = (phase == PH_HALT);
        irq_taken = save;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            phase <= PH_FETCH_REQ;
            pc    <= RESET_PC;
            acc   <= '0;
            ir    <= '0;
        end else begin
            case (phase)
                PH_FETCH_REQ: phase <= PH_FETCH_WAIT;
                PH_FETCH_WAIT: begin
                    ir    <= instr_t'(rdata);
                    pc    <= pc + 1'b1;
                    phase <= PH_EXEC;
                end
                PH_EXEC: begin
                    case (kind)
                        K_LOAD, K_ADD: phase <= PH_OPER_WAIT;
                        K_RETI: begin
                            pc    <= saved.pc;
                            acc   <= saved.acc;
                            phase <= PH_ICHECK;
                        end
                        K_HALT:  phase <= PH_HALT;
                        default: phase <= PH_ICHECK;
                    endcase
                end
                PH_OPER_WAIT: begin
                    acc   <= (kind == K_LOAD) ? rdata : acc + rdata;
                    phase <= PH_ICHECK;
                end
                PH_ICHECK: begin
                    if (save) begin
                        pc <= HANDLER_PC;
                    end
                    phase <= PH_FETCH_REQ;
                end
                default: phase <= PH_HALT;
            endcase
        end
    end
endmodule

// File: rtl/acc_cpu.sv
module acc_cpu
    import acc_cpu_pkg::*;
#(
    parameter logic [ADDR_W-1:0] RESET_PC   = 12'h300,
    parameter logic [ADDR_W-1:0] HANDLER_PC = 12'h100
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              ld_en,
    input  logic [ADDR_W-1:0] ld_addr,
    input  logic [WORD_W-1:0] ld_data,
    input  logic              irq,
    output logic              halted,
    output logic [ADDR_W-1:0] pc_out,
    output logic [WORD_W-1:0] acc_out,
    output logic              int_en,
    output logic              irq_taken,
    output logic              st_valid,
    output logic [ADDR_W-1:0] st_addr,
    output logic [WORD_W-1:0] st_data
);
    logic [WORD_W-1:0] rdata;
    logic [ADDR_W-1:0] rd_addr;
    logic              cpu_we;
    logic [ADDR_W-1:0] cpu_waddr;
    logic [WORD_W-1:0] cpu_wdata;
    logic              save;
    logic              restore;
    context_t          live;
    context_t          saved;
    logic              mem_we;
    logic [ADDR_W-1:0] mem_waddr;
    logic [WORD_W-1:0] mem_wdata;

    always_comb begin
        if (rst) begin
            mem_we    = ld_en;
            mem_waddr = ld_addr;
            mem_wdata = ld_data;
        end else begin
            mem_we    = cpu_we;
            mem_waddr = cpu_waddr;
            mem_wdata = cpu_wdata;
        end
    end

    acc_mem #(.AW(ADDR_W), .DW(WORD_W)) u_mem (
        .clk   (clk),
        .we    (mem_we),
        .waddr (mem_waddr),
        .wdata (mem_wdata),
        .raddr (rd_addr),
        .rdata (rdata)
    );

    acc_ctx u_ctx (
        .clk     (clk),
        .rst     (rst),
        .save    (save),
        .restore (restore),
        .live    (live),
        .saved   (saved),
        .int_en  (int_en)
    );

    acc_ctrl #(.RESET_PC(RESET_PC), .HANDLER_PC(HANDLER_PC)) u_ctrl (
        .clk       (clk),
        .rst       (rst),
        .rdata     (rdata),
        .irq       (irq),
        .int_en    (int_en),
        .saved     (saved),
        .rd_addr   (rd_addr),
        .wr_en     (cpu_we),
        .wr_addr   (cpu_waddr),
        .wr_data   (cpu_wdata),
        .save      (save),
        .restore   (restore),
        .live      (live),
        .halted    (halted),
        .irq_taken (irq_taken)
    );

    assign pc_out   = live.pc;
    assign acc_out  = live.acc;
    assign st_valid = cpu_we && !rst;
    assign st_addr  = cpu_waddr;
    assign st_data  = cpu_wdata;
endmodule

// File: rtl/acc_cpu_chk.sv
module acc_cpu_chk
    import acc_cpu_pkg::*;
#(
    parameter logic [ADDR_W-1:0] RESET_PC   = 12'h300,
    parameter logic [ADDR_W-1:0] HANDLER_PC = 12'h100
) (
    input logic              clk,
    input logic              rst,
    input logic              halted,
    input logic [ADDR_W-1:0] pc_out,
    input logic [WORD_W-1:0] acc_out,
    input logic              int_en,
    input logic              irq_taken,
    input logic              st_valid
);
    assert_reset_state_R1: assert property (@(posedge clk) disable iff (rst)
        $fell(rst) |-> (pc_out == RESET_PC) && (acc_out == '0) && int_en && !halted);

    assert_store_keeps_acc_R4: assert property (@(posedge clk) disable iff (rst)
        st_valid |=> acc_out == $past(acc_out));

    assert_take_vectors_R6: assert property (@(posedge clk) disable iff (rst)
        irq_taken |=> (pc_out == HANDLER_PC) && !int_en);

    assert_masked_no_take_R7: assert property (@(posedge clk) disable iff (rst)
        !int_en |-> !irq_taken);

    assert_halt_frozen_R9: assert property (@(posedge clk) disable iff (rst)
        halted |=> halted && $stable(pc_out) && $stable(acc_out));

    assert_halt_no_store_R9: assert property (@(posedge clk) disable iff (rst)
        halted |-> !st_valid);

    assert_take_not_store_R6: assert property (@(posedge clk) disable iff (rst)
        irq_taken |-> !st_valid);
endmodule

bind acc_cpu acc_cpu_chk #(.RESET_PC(RESET_PC), .HANDLER_PC(HANDLER_PC)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .halted    (halted),
    .pc_out    (pc_out),
    .acc_out   (acc_out),
    .int_en    (int_en),
    .irq_taken (irq_taken),
    .st_valid  (st_valid)
);

// File: tb/acc_cpu_tb.sv
`timescale 1ns/1ps
module acc_cpu_tb;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        ld_en = 1'b0;
    logic [11:0] ld_addr = '0;
    logic [15:0] ld_data = '0;
    logic        irq = 1'b0;
    logic        halted, int_en, irq_taken, st_valid;
    logic [11:0] pc_out, st_addr;
    logic [15:0] acc_out, st_data;

    int total = 0;
    int bad = 0;
    int cyc = 0;
    int takes = 0;
    int nst = 0;
    int st_cyc [16];
    bit done = 1'b0;
    logic [11:0] exp_addr [$];
    logic [15:0] exp_data [$];
    string       exp_req  [$];

    acc_cpu u_dut (
        .clk(clk), .rst(rst), .ld_en(ld_en), .ld_addr(ld_addr), .ld_data(ld_data),
        .irq(irq), .halted(halted), .pc_out(pc_out), .acc_out(acc_out),
        .int_en(int_en), .irq_taken(irq_taken), .st_valid(st_valid),
        .st_addr(st_addr), .st_data(st_data)
    );

    always #2.5 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] expv);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s actual=0x%0h expected=0x%0h", req, what, act, expv);
        end
    endtask

    task automatic poke(input logic [11:0] a, input logic [15:0] d);
        @(negedge clk);
        ld_en = 1'b1; ld_addr = a; ld_data = d;
        @(negedge clk);
        ld_en = 1'b0;
    endtask

    task automatic expect_store(input logic [11:0] a, input logic [15:0] d, input string req);
        exp_addr.push_back(a);
        exp_data.push_back(d);
        exp_req.push_back(req);
    endtask

    // monitor: pops the scoreboard on every processor write
    always @(negedge clk) begin
        if (!rst && irq_taken) takes++;
        if (!rst && st_valid) begin
            if (nst < 16) st_cyc[nst] = cyc;
            nst++;
            if (exp_addr.size() == 0) begin
                chk(1'b0, "R9", "unexpected store addr", {20'h0, st_addr}, 32'h0);
            end else begin
                logic [11:0] ea;
                logic [15:0] ed;
                string       er;
                ea = exp_addr.pop_front();
                ed = exp_data.pop_front();
                er = exp_req.pop_front();
                chk(st_addr == ea, er, "store addr", {20'h0, st_addr}, {20'h0, ea});
                chk(st_data == ed, er, "store data", {16'h0, st_data}, {16'h0, ed});
            end
        end
    end

    initial begin
        repeat (3000) @(posedge clk);
        if (!done) begin
            chk(1'b0, "R9", "watchdog expired, halted", {31'h0, halted}, 32'h1);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        // program (opcode in bits 15:12, address in 11:0)
        poke(12'h300, 16'h1940); // load 3
        poke(12'h301, 16'h5941); // add 2
        poke(12'h302, 16'h2941); // store 5
        poke(12'h303, 16'h1941); // reload 5
        poke(12'h304, 16'h5940); // add 3 -> 8
        poke(12'h305, 16'h2950); // store 8
        poke(12'h306, 16'h3000); // unused opcode
        poke(12'h307, 16'h2951); // store 8
        poke(12'h308, 16'h5942); // add 0xFFFF -> 7
        poke(12'h309, 16'h2952);
        poke(12'h30A, 16'h2953);
        poke(12'h30B, 16'h2954);
        poke(12'h30C, 16'hF000); // halt
        poke(12'h940, 16'h0003);
        poke(12'h941, 16'h0002);
        poke(12'h942, 16'hFFFF);
        poke(12'h960, 16'h1234);
        poke(12'h100, 16'h1960); // handler: load
        poke(12'h101, 16'h2961); // store
        poke(12'h102, 16'hE000); // return

        expect_store(12'h941, 16'h0005, "R3");
        expect_store(12'h950, 16'h0008, "R4");
        expect_store(12'h951, 16'h0008, "R11");
        expect_store(12'h961, 16'h1234, "R2");
        expect_store(12'h952, 16'h0007, "R8");
        expect_store(12'h953, 16'h0007, "R8");
        expect_store(12'h954, 16'h0007, "R10");

        @(negedge clk);
        chk(pc_out == 12'h300, "R1", "reset pc", {20'h0, pc_out}, 32'h300);
        chk(acc_out == 16'h0, "R1", "reset acc", {16'h0, acc_out}, 32'h0);
        chk(int_en && !halted && !st_valid, "R1", "reset flags",
            {29'h0, int_en, halted, st_valid}, 32'h4);
        rst = 1'b0;

        // R10: loader writes after reset must be ignored
        @(negedge clk);
        ld_en = 1'b1; ld_addr = 12'h942; ld_data = 16'h0100;
        @(negedge clk);
        ld_en = 1'b0;

        // raise irq right after the store to 0x951 is seen
        while (!(st_valid && st_addr == 12'h951)) @(negedge clk);
        irq = 1'b1;
        @(negedge clk);
        chk(irq_taken == 1'b1, "R6", "irq taken in check phase", {31'h0, irq_taken}, 32'h1);
        chk(pc_out == 12'h308, "R8", "return address", {20'h0, pc_out}, 32'h308);
        @(negedge clk);
        chk(pc_out == 12'h100, "R6", "handler pc", {20'h0, pc_out}, 32'h100);
        chk(int_en == 1'b0, "R6", "enable cleared", {31'h0, int_en}, 32'h0);

        // hold irq through the masked handler until its store
        while (!(st_valid && st_addr == 12'h961)) @(negedge clk);
        irq = 1'b0;
        chk(takes == 1, "R7", "masked irq not retaken", takes, 32'h1);

        while (!halted) @(negedge clk);
        repeat (10) @(negedge clk);
        chk(halted == 1'b1, "R9", "halted stays", {31'h0, halted}, 32'h1);
        chk(pc_out == 12'h30D, "R9", "frozen pc", {20'h0, pc_out}, 32'h30D);
        chk(acc_out == 16'h0007, "R3", "final acc wrap", {16'h0, acc_out}, 32'h7);
        chk(int_en == 1'b1, "R8", "enable restored", {31'h0, int_en}, 32'h1);
        chk(takes == 1, "R7", "single interrupt", takes, 32'h1);
        chk(nst == 7, "R9", "store count", nst, 32'd7);
        chk(st_cyc[1] - st_cyc[0] == 14, "R5", "load+add+store cycles",
            st_cyc[1] - st_cyc[0], 32'd14);
        chk(st_cyc[2] - st_cyc[1] == 8, "R5", "nop+store cycles",
            st_cyc[2] - st_cyc[1], 32'd8);
        chk(st_cyc[5] - st_cyc[4] == 4, "R5", "store to store cycles",
            st_cyc[5] - st_cyc[4], 32'd4);

        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule